// File: doc/BRIEF.md
# Serial Save-Memory Slave

This block is the target side of a four-wire serial link to a battery-backed save memory. A host lowers the select line, clocks a one-byte command in, and, for commands that need one, follows it with address bytes and a stream of data bytes. The slave answers on its output line during the same bytes. The storage is an internal byte array, and a status byte holds a write-enable latch.

Two memory styles are supported through a static configuration input. The EEPROM style takes a two-byte address and the flash style a three-byte address. The configuration may change only while the slave is not selected. Besides plain read and program, a page-write command hands back the byte that a location held while it stores the new one. This allows a read-modify-write in a single pass.

The serial pins are resampled in the system clock domain, so the serial clock must be slow compared with `clk`. The link is mode 0: data is captured on the rising serial clock edge, the output changes on the falling edge, and each byte travels most significant bit first.

Top module: `spiSaveMem`

## Requirements
- R1: The first byte received after `csN` falls is taken as the command, and the internal address register is cleared at that point. Raising `csN` abandons a transaction, including any partial byte, and the next selection starts again with a command byte.
- R2: With `flashMode` high, a command that takes an address is followed by three address bytes; with `flashMode` low it is followed by two. Address bytes are shifted in most significant byte first.
- R3: Command 0x06 sets bit 1 of the status byte (write enable) and command 0x04 clears it. Either takes effect when its command byte completes.
- R4: After command 0x05, every following byte returns the status byte {6'b0, writeEnable, 1'b0}.
- R5: After command 0x03 and its address, each data byte returns the stored byte at the current address, and the address then advances by one.
- R6: After command 0x02 and its address, each data byte is stored at the current address while write enable is set, and the address then advances by one.
- R7: After command 0x0A and its address, each data byte returns the byte previously held at the current address. The incoming byte is stored there when write enable is set, and the address then advances by one.
- R8: The output line carries all ones during the command byte, during address bytes, and on every byte that follows a command other than 0x02, 0x03, 0x05 and 0x0A. It is also all ones after reset.
- R9: A location never written since reset reads as 0xFF.
- R10: While write enable is clear, commands 0x02 and 0x0A leave the array unchanged, but the address still advances.
- R11: Raising `csN` after a 0x02 or 0x0A command clears write enable.
- R12: Only the low log2(DEPTH) bits of the address select a location, so addresses wrap modulo DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all pins are resampled on it |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host, idle low |
| mosi | input | 1 | Serial data from the host |
| flashMode | input | 1 | 1 selects three address bytes, 0 selects two |
| miso | output | 1 | Serial data to the host |

## Verification
The checker watches four things on every cycle: the output stays high through command and address phases, the address is zero whenever a command byte completes, a read step advances the address by exactly one, and the write-enable latch moves only on its set or clear strobes and drops when a program transaction is deselected. The values that actually cross the link can only be shown by the bench's scenarios. These include stored data returned after a later selection, the old byte returned by a page write, the array left untouched while write enable is clear, address wrap-around, and the switch between two- and three-byte addressing.

// File: rtl/spiSavePkg.sv
package spiSavePkg;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_WRDI   = 8'h04;
  localparam logic [7:0] CMD_RDSR   = 8'h05;
  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_PGWR   = 8'h0A;
  localparam int ADDR_BYTES_EE    = 2;
  localparam int ADDR_BYTES_FLASH = 3;
  localparam int ADDR_W           = 8 * ADDR_BYTES_FLASH;

  typedef enum logic [1:0] {PH_CMD, PH_ADDR, PH_DATA} phase_t;
  typedef enum logic [1:0] {TX_ONES, TX_STATUS, TX_MEM} txSel_t;

  typedef struct packed {
    logic   start;
    logic   addrShift;
    logic   addrInc;
    logic   memWrite;
    logic   setWel;
    logic   clrWel;
    logic   shiftTx;
    logic   loadTx;
    txSel_t txSel;
  } strobe_t;
endpackage

// File: rtl/spiSaveCtrl.sv
module spiSaveCtrl
  import spiSavePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       mosi,
  input  logic       flashMode,
  output strobe_t    stb,
  output logic [7:0] rxByte,
  output phase_t     phase,
  output logic [7:0] cmd,
  output logic       byteDone,
  output logic       selected,
  output logic       csRiseEv,
  output logic       progSeen
);
  logic [1:0] sckSync, csSync, mosiSync;
  logic       sckPrev, csPrev;
  logic [2:0] bitCnt;
  logic [7:0] rxShift;
  logic [1:0] addrLeft;
  logic       loadPend;
  logic       csFallEv, sckRiseEv, sckFallEv;

  assign selected  = !csSync[1];
  assign csFallEv  = csPrev && !csSync[1];
  assign csRiseEv  = !csPrev && csSync[1];
  assign sckRiseEv = selected && sckSync[1] && !sckPrev;
  assign sckFallEv = selected && !sckSync[1] && sckPrev;
  assign rxByte    = rxShift;

  function automatic logic needsAddr(input logic [7:0] c);
    return (c == CMD_READ) || (c == CMD_PROG) || (c == CMD_PGWR);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync  <= 2'b00;
      csSync   <= 2'b11;
      mosiSync <= 2'b00;
      sckPrev  <= 1'b0;
      csPrev   <= 1'b1;
      bitCnt   <= '0;
      rxShift  <= '0;
      byteDone <= 1'b0;
      loadPend <= 1'b0;
      phase    <= PH_CMD;
      cmd      <= '0;
      addrLeft <= '0;
      progSeen <= 1'b0;
    end else begin
      sckSync  <= {sckSync[0], sck};
      csSync   <= {csSync[0], csN};
      mosiSync <= {mosiSync[0], mosi};
      sckPrev  <= sckSync[1];
      csPrev   <= csSync[1];
      byteDone <= 1'b0;
      loadPend <= byteDone;
      if (sckRiseEv) begin
        rxShift <= {rxShift[6:0], mosiSync[1]};
        bitCnt  <= bitCnt + 3'd1;
        if (bitCnt == 3'd7) byteDone <= 1'b1;
      end
      if (byteDone) begin
        unique case (phase)
          PH_CMD: begin
            cmd <= rxShift;
            if (needsAddr(rxShift)) begin
              phase    <= PH_ADDR;
              addrLeft <= flashMode ? 2'(ADDR_BYTES_FLASH) : 2'(ADDR_BYTES_EE);
            end else begin
              phase <= PH_DATA;
            end
            if (rxShift == CMD_PROG || rxShift == CMD_PGWR) progSeen <= 1'b1;
          end
          PH_ADDR: begin
            addrLeft <= addrLeft - 2'd1;
            if (addrLeft == 2'd1) phase <= PH_DATA;
          end
          default: ;
        endcase
      end
      if (csFallEv || csRiseEv) begin
        bitCnt   <= '0;
        phase    <= PH_CMD;
        byteDone <= 1'b0;
        loadPend <= 1'b0;
      end
      if (csFallEv) progSeen <= 1'b0;
    end
  end

  always_comb begin
    stb           = '0;
    stb.start     = csFallEv;
    stb.shiftTx   = sckFallEv && (bitCnt != 3'd0);
    stb.setWel    = byteDone && phase == PH_CMD && rxShift == CMD_WREN;
    stb.clrWel    = (csRiseEv && progSeen) ||
                    (byteDone && phase == PH_CMD && rxShift == CMD_WRDI);
    stb.addrShift = byteDone && phase == PH_ADDR;
    stb.memWrite  = byteDone && phase == PH_DATA && (cmd == CMD_PROG || cmd == CMD_PGWR);
    stb.addrInc   = byteDone && phase == PH_DATA && needsAddr(cmd);
    stb.loadTx    = loadPend && selected;
    stb.txSel     = TX_ONES;
    if (phase == PH_DATA) begin
      if (cmd == CMD_RDSR) stb.txSel = TX_STATUS;
      else if (cmd == CMD_READ || cmd == CMD_PGWR) stb.txSel = TX_MEM;
    end
  end
endmodule

// File: rtl/spiSaveDatapath.sv
module spiSaveDatapath
  import spiSavePkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [7:0]        rxByte,
  output logic              miso,
  output logic              wel,
  output logic [ADDR_W-1:0] addr
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]       mem [DEPTH];
  logic [DEPTH-1:0] written;
  logic [7:0]       txShift;
  logic [IDX_W-1:0] idx;
  logic [7:0]       memRd;
  logic [7:0]       txVal;
  logic             doWrite;

  assign idx     = addr[IDX_W-1:0];
  assign memRd   = written[idx] ? mem[idx] : 8'hFF;
  assign doWrite = stb.memWrite && wel;
  assign miso    = txShift[7];

  always_comb begin
    unique case (stb.txSel)
      TX_STATUS: txVal = {6'b0, wel, 1'b0};
      TX_MEM:    txVal = memRd;
      default:   txVal = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr    <= '0;
      wel     <= 1'b0;
      txShift <= 8'hFF;
      written <= '0;
    end else begin
      if (stb.start) begin
        addr    <= '0;
        txShift <= 8'hFF;
      end
      if (stb.addrShift) addr <= {addr[ADDR_W-9:0], rxByte};
      if (stb.addrInc)   addr <= addr + 1'b1;
      if (stb.setWel)    wel <= 1'b1;
      if (stb.clrWel)    wel <= 1'b0;
      if (doWrite)       written[idx] <= 1'b1;
      if (stb.shiftTx)   txShift <= {txShift[6:0], 1'b1};
      if (stb.loadTx)    txShift <= txVal;
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) mem[idx] <= rxByte;
  end
endmodule

// File: rtl/spiSaveMem.sv
module spiSaveMem
  import spiSavePkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic mosi,
  input  logic flashMode,
  output logic miso
);
  strobe_t           stb;
  logic [7:0]        rxByte;
  phase_t            phase;
  logic [7:0]        cmd;
  logic              byteDone, selected, csRiseEv, progSeen, wel;
  logic [ADDR_W-1:0] addr;

  spiSaveCtrl uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .flashMode(flashMode), .stb(stb), .rxByte(rxByte), .phase(phase),
    .cmd(cmd), .byteDone(byteDone), .selected(selected),
    .csRiseEv(csRiseEv), .progSeen(progSeen)
  );

  spiSaveDatapath #(.DEPTH(DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte),
    .miso(miso), .wel(wel), .addr(addr)
  );
endmodule

// File: rtl/spiSaveChecker.sv
module spiSaveChecker
  import spiSavePkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              miso,
  input strobe_t           stb,
  input phase_t            phase,
  input logic [7:0]        cmd,
  input logic              byteDone,
  input logic              selected,
  input logic              csRiseEv,
  input logic              progSeen,
  input logic              wel,
  input logic [ADDR_W-1:0] addr
);
  p_ones_before_data_r8: assert property (@(posedge clk) disable iff (!rstN)
    (selected && !stb.start && phase != PH_DATA) |-> miso);

  p_addr_zero_at_cmd_r1: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && phase == PH_CMD) |-> (addr == '0));

  p_read_advance_r5: assert property (@(posedge clk) disable iff (!rstN)
    (byteDone && phase == PH_DATA && cmd == CMD_READ) |=> (addr == $past(addr) + 1'b1));

  p_wel_drop_r11: assert property (@(posedge clk) disable iff (!rstN)
    (csRiseEv && progSeen) |=> !wel);

  p_wel_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.setWel && !stb.clrWel) |=> $stable(wel));

  p_wel_strobes_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.setWel, stb.clrWel}));
endmodule

bind spiSaveMem spiSaveChecker uChk (
  .clk(clk), .rstN(rstN), .miso(miso), .stb(stb), .phase(phase),
  .cmd(cmd), .byteDone(byteDone), .selected(selected),
  .csRiseEv(csRiseEv), .progSeen(progSeen), .wel(wel), .addr(addr)
);

// File: tb/tb_spiSaveMem.sv
module tb_spiSaveMem;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  logic flashMode = 1'b0;
  logic miso;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spiSaveMem #(.DEPTH(256)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
    .flashMode(flashMode), .miso(miso)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic select();
    @(negedge clk);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic deselect();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      r[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic sendAddr(input logic [23:0] a, input string req);
    logic [7:0] r;
    if (flashMode) begin
      xfer(a[23:16], r);
      check(req, r, 8'hFF);
    end
    xfer(a[15:8], r);
    check(req, r, 8'hFF);
    xfer(a[7:0], r);
    check(req, r, 8'hFF);
  endtask

  task automatic oneByteCmd(input logic [7:0] c);
    logic [7:0] r;
    select();
    xfer(c, r);
    check("R8 command byte", r, 8'hFF);
    deselect();
  endtask

  task automatic readStatus(input logic [7:0] exp, input string req);
    logic [7:0] r;
    select();
    xfer(8'h05, r);
    xfer(8'h00, r);
    check(req, r, exp);
    xfer(8'h00, r);
    check(req, r, exp);
    deselect();
  endtask

  task automatic readBytes(input logic [23:0] a, input logic [7:0] e0,
                           input logic [7:0] e1, input string req);
    logic [7:0] r;
    select();
    xfer(8'h03, r);
    check("R8 read command", r, 8'hFF);
    sendAddr(a, "R8 address bytes");
    xfer(8'h00, r);
    check(req, r, e0);
    xfer(8'h00, r);
    check(req, r, e1);
    deselect();
  endtask

  task automatic t_reset();
    check("R8 reset output", {7'b0, miso}, 8'h01);
  endtask

  task automatic t_unwritten();
    readBytes(24'h000040, 8'hFF, 8'hFF, "R9 unwritten reads FF");
  endtask

  task automatic t_blocked();
    logic [7:0] r;
    select();
    xfer(8'h02, r);
    sendAddr(24'h000010, "R8 address bytes");
    xfer(8'hAA, r);
    xfer(8'hBB, r);
    deselect();
    readBytes(24'h000010, 8'hFF, 8'hFF, "R10 write blocked without enable");
  endtask

  task automatic t_status();
    oneByteCmd(8'h06);
    readStatus(8'h02, "R3 R4 status after 0x06");
    oneByteCmd(8'h04);
    readStatus(8'h00, "R3 R4 status after 0x04");
  endtask

  task automatic t_program();
    logic [7:0] r;
    oneByteCmd(8'h06);
    select();
    xfer(8'h02, r);
    sendAddr(24'h000020, "R8 address bytes");
    xfer(8'h11, r);
    xfer(8'h22, r);
    xfer(8'h33, r);
    deselect();
    readStatus(8'h00, "R11 enable cleared after program");
    readBytes(24'h000020, 8'h11, 8'h22, "R5 R6 program then read");
    readBytes(24'h000022, 8'h33, 8'hFF, "R5 R6 address advanced");
  endtask

  task automatic t_unsupported();
    logic [7:0] r;
    select();
    xfer(8'h9F, r);
    xfer(8'h20, r);
    check("R8 unsupported command", r, 8'hFF);
    xfer(8'h00, r);
    check("R8 unsupported command", r, 8'hFF);
    deselect();
  endtask

  task automatic t_pageWrite();
    logic [7:0] r;
    oneByteCmd(8'h06);
    select();
    xfer(8'h0A, r);
    sendAddr(24'h000021, "R8 address bytes");
    xfer(8'h44, r);
    check("R7 old byte returned", r, 8'h22);
    xfer(8'h55, r);
    check("R7 old byte returned", r, 8'h33);
    deselect();
    readBytes(24'h000021, 8'h44, 8'h55, "R7 new bytes stored");
    select();
    xfer(8'h0A, r);
    sendAddr(24'h000021, "R8 address bytes");
    xfer(8'h99, r);
    check("R10 page write without enable returns old", r, 8'h44);
    deselect();
    readBytes(24'h000021, 8'h44, 8'h55, "R10 page write without enable");
  endtask

  task automatic t_abort();
    logic [7:0] r;
    select();
    xfer(8'h03, r);
    xfer(8'h00, r);
    mosi = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
    deselect();
    readStatus(8'h00, "R1 command after aborted transaction");
  endtask

  task automatic t_flash();
    logic [7:0] r;
    flashMode = 1'b1;
    oneByteCmd(8'h06);
    select();
    xfer(8'h02, r);
    sendAddr(24'h000030, "R2 flash address bytes");
    xfer(8'h77, r);
    deselect();
    readBytes(24'h000030, 8'h77, 8'hFF, "R2 three-byte address");
    flashMode = 1'b0;
    readBytes(24'h000030, 8'h77, 8'hFF, "R2 two-byte address");
  endtask

  task automatic t_wrap();
    logic [7:0] r;
    oneByteCmd(8'h06);
    select();
    xfer(8'h02, r);
    sendAddr(24'h0001FF, "R8 address bytes");
    xfer(8'h66, r);
    xfer(8'h67, r);
    deselect();
    readBytes(24'h0000FF, 8'h66, 8'h67, "R12 address wraps");
  endtask

  initial begin : watchdog
    for (int n = 0; n < 150000; n++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unwritten();
    t_blocked();
    t_status();
    t_program();
    t_unsupported();
    t_pageWrite();
    t_abort();
    t_flash();
    t_wrap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule